// File: doc/BRIEF.md
# Synchronous Rectifier Gate Timer

This block drives the gate of one synchronous-rectifier switch in a resonant converter. Its only view of the power stage is a digitized drain-sense level. That level goes low while the switch's body diode or channel carries current. The block waits a fixed delay after the sense falls, then turns the gate on. Each time the sense is low, the block counts in clock ticks how long it stays low.

The gate is not switched off by detecting zero current. Instead, the turn-off instant is predicted from the conduction time measured in the previous cycle. The block subtracts a programmable dead time and any pending shrink amount from that measurement, and the gate turns off when the current low period reaches the result. If the sense rises before that point, the gate drops at once. When the last measured conduction is short, the load is light, and the gate is held off to save drive power. The limit for this light-load test depends on the selected frequency mode. One instance serves one rectifier, so a centre-tapped secondary uses two.

Top module: `sr_gate_timer`

## Requirements
- R1: While reset is asserted, and in the cycles after it is released, `gate_o` is low.
- R2: The gate turns on 35 ticks after the sense falls (15 debounce plus 20 propagation). With the sense sampled low for the first time at edge E0, `gate_o` is first high after edge E36.
- R3: A low period of N ticks (N of at least 15) is captured as the conduction time N. A new value is captured in every switching cycle and is used in the next cycle.
- R4: The turn-off point is P = previous conduction − `dead_time_i` − `shrink_i`, counted in ticks from the falling edge of the sense. The gate is high for P − 35 ticks when the sense stays low past P.
- R5: The amount on `shrink_i` is subtracted from the on-time. If P is zero or less, the gate stays off for the whole cycle.
- R6: When the sense returns high before P, the gate goes low one tick later. The on-time is then N − 35 ticks.
- R7: After reset, no conduction time has been captured yet, and the gate stays off until one has.
- R8: When `hf_mode_i` = 0, the gate is held off for the whole cycle if the last captured conduction time is below 375 ticks.
- R9: When `hf_mode_i` = 1, the light-load limit is 190 ticks. A conduction time of 300 therefore enables the gate in this mode.
- R10: A low pulse shorter than 15 ticks is treated as a glitch. It is not captured, and the previous conduction time stays in use.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Tick clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sense_i | input | 1 | Drain-sense level, low while conducting |
| dead_time_i | input | 12 | Dead time in ticks |
| hf_mode_i | input | 1 | 1 selects the high-frequency light-load limit |
| shrink_i | input | 12 | Pending shrink amount in ticks |
| gate_o | output | 1 | Gate drive |

## Verification
Take E0 as the first edge that samples the sense low. The gate is then high from the sample after edge E36 through the sample after edge E(min(P, N)). The captured conduction time is available one edge after the sense rises, in time for the next pulse. The bench drives the sense on falling clock edges and samples `gate_o` after each rising edge. For each pulse it counts the high samples and records the index of the first one, and compares both with the values the requirements give. Glitch handling and the light-load limits are each checked by a follow-up pulse, whose on-time shows which conduction time the block kept.

// File: rtl/sr_gate_pkg.sv
package sr_gate_pkg;
  localparam int unsigned CNT_W = 12;
  typedef logic [CNT_W-1:0] tick_t;
  typedef struct packed {
    logic  valid;
    tick_t dur;
  } meas_t;
endpackage

// File: rtl/sr_cond_meter.sv
module sr_cond_meter
  import sr_gate_pkg::*;
#(
  parameter int unsigned DB_TICKS = 15
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sense_i,
  output logic  sense_q_o,
  output tick_t low_cnt_o,
  output meas_t meas_o
);
  localparam tick_t CNT_MAX = '1;
  localparam tick_t DB_C    = CNT_W'(DB_TICKS);

  logic  sense_q;
  tick_t low_cnt_q, low_cnt_d;
  meas_t meas_q, meas_d;
  logic  cap_en;

  always_comb begin
    low_cnt_d = low_cnt_q;
    if (sense_q) begin
      low_cnt_d = '0;
    end else if (low_cnt_q != CNT_MAX) begin
      low_cnt_d = low_cnt_q + 1'b1;
    end
  end

  assign cap_en = sense_q && (low_cnt_q >= DB_C);

  always_comb begin
    meas_d = meas_q;
    if (cap_en) begin
      meas_d.valid = 1'b1;
      meas_d.dur   = low_cnt_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sense_q   <= 1'b1;
      low_cnt_q <= '0;
      meas_q    <= '0;
    end else begin
      sense_q   <= sense_i;
      low_cnt_q <= low_cnt_d;
      if (cap_en) begin
        meas_q <= meas_d;
      end
    end
  end

  assign sense_q_o = sense_q;
  assign low_cnt_o = low_cnt_q;
  assign meas_o    = meas_q;

  // R3
  cnt_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sense_q && low_cnt_q == CNT_MAX) |=> (low_cnt_q == CNT_MAX));

  // R10
  glitch_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sense_q && low_cnt_q != '0 && low_cnt_q < DB_C) |=> $stable(meas_q));
endmodule

// File: rtl/sr_turnoff_calc.sv
module sr_turnoff_calc
  import sr_gate_pkg::*;
#(
  parameter int unsigned GREEN_LF_TICKS = 375,
  parameter int unsigned GREEN_HF_TICKS = 190
) (
  input  meas_t meas_i,
  input  tick_t dead_time_i,
  input  tick_t shrink_i,
  input  logic  hf_mode_i,
  output tick_t off_pt_o,
  output logic  green_o
);
  localparam int unsigned DW = CNT_W + 2;
  localparam tick_t LF_C = CNT_W'(GREEN_LF_TICKS);
  localparam tick_t HF_C = CNT_W'(GREEN_HF_TICKS);

  logic signed [DW-1:0] diff;
  logic                 nonpos;
  tick_t                thr;

  always_comb begin
    diff   = $signed({2'b00, meas_i.dur}) - $signed({2'b00, dead_time_i})
           - $signed({2'b00, shrink_i});
    nonpos = (diff <= 0);
    off_pt_o = nonpos ? '0 : diff[CNT_W-1:0];
    thr     = hf_mode_i ? HF_C : LF_C;
    green_o = meas_i.valid && (meas_i.dur < thr);
  end
endmodule

// File: rtl/sr_gate_drive.sv
module sr_gate_drive
  import sr_gate_pkg::*;
#(
  parameter int unsigned ON_DLY = 35
) (
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  sense_q_i,
  input  tick_t low_cnt_i,
  input  logic  valid_i,
  input  logic  green_i,
  input  tick_t off_pt_i,
  output logic  gate_o
);
  localparam tick_t ON_C = CNT_W'(ON_DLY);

  logic gate_q, gate_d;

  always_comb begin
    gate_d = valid_i && !green_i && !sense_q_i &&
             (low_cnt_i >= ON_C) && (low_cnt_i < off_pt_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q <= 1'b0;
    end else begin
      gate_q <= gate_d;
    end
  end

  assign gate_o = gate_q;

  // R6
  forced_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sense_q_i |=> !gate_q);

  // R7
  no_meas_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> !gate_q);

  // R8 R9
  green_block_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    green_i |=> !gate_q);

  // R2
  on_delay_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(gate_q) |-> ($past(low_cnt_i) >= ON_C));
endmodule

// File: rtl/sr_gate_timer.sv
module sr_gate_timer
  import sr_gate_pkg::*;
#(
  parameter int unsigned DB_TICKS       = 15,
  parameter int unsigned PD_TICKS       = 20,
  parameter int unsigned GREEN_LF_TICKS = 375,
  parameter int unsigned GREEN_HF_TICKS = 190
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sense_i,
  input  logic [CNT_W-1:0] dead_time_i,
  input  logic             hf_mode_i,
  input  logic [CNT_W-1:0] shrink_i,
  output logic             gate_o
);
  localparam int unsigned ON_DLY = DB_TICKS + PD_TICKS;

  logic [1:0] rst_sync_q;
  logic       rst_n_int;
  logic       sense_q;
  tick_t      low_cnt;
  meas_t      meas;
  tick_t      off_pt;
  logic       green;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n_int = rst_sync_q[1];

  sr_cond_meter #(.DB_TICKS(DB_TICKS)) meter_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .sense_i   (sense_i),
    .sense_q_o (sense_q),
    .low_cnt_o (low_cnt),
    .meas_o    (meas)
  );

  sr_turnoff_calc #(
    .GREEN_LF_TICKS(GREEN_LF_TICKS),
    .GREEN_HF_TICKS(GREEN_HF_TICKS)
  ) calc_i (
    .meas_i      (meas),
    .dead_time_i (dead_time_i),
    .shrink_i    (shrink_i),
    .hf_mode_i   (hf_mode_i),
    .off_pt_o    (off_pt),
    .green_o     (green)
  );

  sr_gate_drive #(.ON_DLY(ON_DLY)) drive_i (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_int),
    .sense_q_i (sense_q),
    .low_cnt_i (low_cnt),
    .valid_i   (meas.valid),
    .green_i   (green),
    .off_pt_i  (off_pt),
    .gate_o    (gate_o)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rst_n_int |=> !gate_o);
endmodule

// File: tb/sr_gate_timer_tb_top.sv
module sr_gate_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sense;
  logic [11:0] dead;
  logic        hf;
  logic [11:0] shrink;
  logic        gate;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  localparam int ON = 35;

  always #2.5 clk = ~clk;

  sr_gate_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .sense_i(sense), .dead_time_i(dead),
    .hf_mode_i(hf), .shrink_i(shrink), .gate_o(gate)
  );

  task automatic check(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse(input int n, output int cnt, output int first);
    cnt = 0;
    first = -1;
    @(negedge clk);
    sense = 1'b0;
    for (int i = 0; i < n + 4; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (gate) begin
        cnt++;
        if (first < 0) first = i;
      end
      if (i == n - 1) sense = 1'b1;
    end
    for (int j = 0; j < 20; j++) begin
      @(negedge clk);
      if (gate) cnt++;
    end
  endtask

  function automatic int exp_cnt(input int prev, input int n, input int dt, input int sh);
    int p;
    int e;
    p = prev - dt - sh;
    if (p < 0) p = 0;
    e = ((p < n) ? p : n) - ON;
    return (e > 0) ? e : 0;
  endfunction

  task automatic t_reset();
    rst_n = 1'b0; sense = 1'b1; dead = 12'd50; hf = 1'b0; shrink = 12'd0;
    repeat (4) @(negedge clk);
    check("R1 gate in reset", int'(gate), 0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R1 gate after reset", int'(gate), 0);
  endtask

  task automatic t_first_and_basic();
    int c, f;
    pulse(500, c, f);
    check("R7 first cycle off", c, 0);
    pulse(500, c, f);
    check("R4 on-time", c, exp_cnt(500, 500, 50, 0));
    check("R2 turn-on index", f, ON + 1);
  endtask

  task automatic t_early_end();
    int c, f;
    pulse(400, c, f);
    check("R6 forced off", c, exp_cnt(500, 400, 50, 0));
    pulse(500, c, f);
    check("R3 measured 400", c, exp_cnt(400, 500, 50, 0));
  endtask

  task automatic t_shrink();
    int c, f;
    shrink = 12'd100;
    pulse(500, c, f);
    check("R5 shrink 100", c, exp_cnt(500, 500, 50, 100));
    shrink = 12'd600;
    pulse(500, c, f);
    check("R5 nonpositive off", c, 0);
    shrink = 12'd0;
  endtask

  task automatic t_glitch();
    int c, f;
    pulse(10, c, f);
    check("R10 glitch no gate", c, 0);
    pulse(500, c, f);
    check("R10 glitch ignored", c, exp_cnt(500, 500, 50, 0));
  endtask

  task automatic t_green_lf();
    int c, f;
    pulse(300, c, f);
    check("R6 short pulse", c, exp_cnt(500, 300, 50, 0));
    pulse(500, c, f);
    check("R8 LF green off", c, 0);
    pulse(500, c, f);
    check("R8 LF green exit", c, exp_cnt(500, 500, 50, 0));
  endtask

  task automatic t_green_hf();
    int c, f;
    hf = 1'b1;
    pulse(300, c, f);
    check("R9 HF 300 pulse", c, exp_cnt(500, 300, 50, 0));
    pulse(500, c, f);
    check("R9 HF 300 not green", c, exp_cnt(300, 500, 50, 0));
    pulse(150, c, f);
    check("R9 HF 150 pulse", c, exp_cnt(500, 150, 50, 0));
    pulse(500, c, f);
    check("R9 HF green off", c, 0);
    hf = 1'b0;
  endtask

  initial begin
    t_reset();
    t_first_and_basic();
    t_early_end();
    t_shrink();
    t_glitch();
    t_green_lf();
    t_green_hf();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule